// File: doc/BRIEF.md
# Subarray Module Control Distributor

This block sits between a subarray's controller and a grid of per-element module control registers arranged in rows and columns. The controller sends one 8-bit control word at a time: it shifts the bits in serially, then raises a strobe together with the target element address. The address carries a row field and a column field. The block adds that element's stored phase calibration offset to the word and shifts the corrected word out to the module. During that shift it drives the row's shared data and strobe lines and a clock that reaches only the addressed module. Because the offsets live here, the modules never need correction data of their own.

The corrected word reaches the module one word time after it was captured. While the controller shifts the next word in, the previous word shifts out. The output strobe comes right after the last outgoing bit. Each module clock is produced by an enable that changes on the falling edge of the system clock. A module clock pulse is therefore always a full high phase of that clock, never a glitch or a runt. Addresses outside the grid produce no clock, no data and no strobe.

Top module: `sa_module_dist`

## Requirements
- R1: A control word is the last 8 bits shifted in (ser_shift high, one bit per cycle, most significant bit first) before the cycle in which ser_stb is high. Bit 7 is the module power enable. Bits 6:0 are the phase code. Extra leading bits are discarded.
- R2: The word delivered to a module has phase = (incoming phase + that element's stored offset) mod 128. The power bit is unchanged.
- R3: If ser_stb is sampled at clock edge s, the addressed module's clock pulses high during the high phases that begin at edges s+1 through s+8, exactly 8 pulses. The row data line carries the corrected word, most significant bit first, and is valid at each of those rising edges.
- R4: At any time at most one module clock is active. Every module other than the one being written keeps its clock low.
- R5: The addressed row's strobe is high from edge s+8 to edge s+9, for one cycle only. Other rows' strobes stay low.
- R6: Data lines of rows not being written, and the data line of the written row outside its 8 shift cycles, are held low.
- R7: A strobe whose row or column lies outside the grid produces no module clock, no data and no strobe anywhere.
- R8: A calibration write (cal_we high) to an in-grid element stores cal_val for that element. A write to an out-of-grid address changes no stored offset. Offsets reset to zero.
- R9: Words may follow back to back, with the next strobe at edge s+9. Each word is still delivered in full to its own module.
- R10: While rst_n is low, all module clocks, data lines and strobes are low.
- R11: Every module clock is low during each low phase of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; module clocks are gated copies of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_shift | input | 1 | Incoming bit valid this cycle |
| ser_data | input | 1 | Incoming serial bit |
| ser_stb | input | 1 | End of word; capture, calibrate and send to ser_addr |
| ser_addr | input | ROW_W+COL_W | Target element {row, column} |
| cal_we | input | 1 | Calibration table write enable |
| cal_addr | input | ROW_W+COL_W | Element {row, column} for the calibration write |
| cal_val | input | 7 | Phase offset to store |
| mod_clk | output | ROWS*COLS | Gated shift clock per element, index row*COLS+column |
| mod_data | output | ROWS | Serial data shared by one row |
| mod_stb | output | ROWS | Apply strobe shared by one row |

## Verification
The hardest condition to reach is the seam between two words sent back to back. In that case one module's eighth clock pulse, the row strobe and the load of the next word share adjacent edges, and the clock enable hands over between elements with no idle cycle between them. The bench drives runs of words with no gap between a strobe and the next word's first bit. It sends them to neighbouring elements in the same row and in different rows. Each cycle is compared against a behavioural model. At the end the applied word captured by each modelled module register is read back.

// File: rtl/sa_dist_pkg.sv
package sa_dist_pkg;

   localparam int unsigned PHASE_W = 7;
   localparam int unsigned WORD_W  = PHASE_W + 1;

   // Corrected word: power bit kept, phase wraps modulo 2**PHASE_W.
   function automatic logic [WORD_W-1:0] apply_cal(input logic [WORD_W-1:0]  w,
                                                   input logic [PHASE_W-1:0] off);
      logic [PHASE_W-1:0] ph;
      ph = w[PHASE_W-1:0] + off;
      return {w[WORD_W-1], ph};
   endfunction

endpackage

// File: rtl/sa_dist_cal_table.sv
module sa_dist_cal_table
   import sa_dist_pkg::*;
#(
   parameter int unsigned NUM   = 16,
   parameter int unsigned IDX_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [PHASE_W-1:0] wr_val,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [PHASE_W-1:0] rd_val
);

   localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM);

   logic [PHASE_W-1:0] mem [NUM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_val;
      end
   end

   assign rd_val = mem[rd_idx];

   // R8: writes only ever reach an in-range entry
   assert_cal_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_idx} < NUM_L));

   // R8: a write is visible in the following cycle
   assert_cal_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/sa_dist_serializer.sv
module sa_dist_serializer
   import sa_dist_pkg::*;
#(
   parameter int unsigned ROW_W = 1,
   parameter int unsigned COL_W = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sh_en,
   input  logic               sh_bit,
   input  logic               ld_en,
   input  logic [ROW_W-1:0]   ld_row,
   input  logic [COL_W-1:0]   ld_col,
   input  logic               ld_hit,
   input  logic [PHASE_W-1:0] ld_off,
   output logic               tx_bit,
   output logic               tx_busy,
   output logic [ROW_W-1:0]   tx_row,
   output logic [COL_W-1:0]   tx_col,
   output logic               tx_hit,
   output logic               tx_stb
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [WORD_W-1:0] in_sr;
   logic [WORD_W-1:0] out_sr;
   logic [CNT_W-1:0]  cnt;

   // capture side: keeps the most recent WORD_W bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_sr <= '0;
      else if (sh_en) in_sr <= {in_sr[WORD_W-2:0], sh_bit};
   end

   // delivery side: one corrected word in flight
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr <= '0;
         cnt    <= '0;
         tx_row <= '0;
         tx_col <= '0;
         tx_hit <= 1'b0;
         tx_stb <= 1'b0;
      end else begin
         tx_stb <= (cnt == LAST) && tx_hit;
         if (ld_en) begin
            out_sr <= apply_cal(in_sr, ld_off);
            cnt    <= FULL;
            tx_row <= ld_row;
            tx_col <= ld_col;
            tx_hit <= ld_hit;
         end else if (cnt != '0) begin
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
            cnt    <= cnt - LAST;
         end
      end
   end

   assign tx_bit  = out_sr[WORD_W-1];
   assign tx_busy = (cnt != '0);

   // R3: a strobe always starts a full word of shift cycles
   assert_load_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cnt == FULL));

endmodule

// File: rtl/sa_dist_clk_gate.sv
module sa_dist_clk_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   output logic en_o,
   output logic gclk
);

   logic en_q;

   // enable moves only on the falling edge, i.e. while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_req;
   end

   assign en_o = en_q;
   assign gclk = clk & en_q;

endmodule

// File: rtl/sa_module_dist.sv
module sa_module_dist
   import sa_dist_pkg::*;
#(
   parameter  int unsigned ROWS   = 2,
   parameter  int unsigned COLS   = 8,
   localparam int unsigned NUM    = ROWS * COLS,
   localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int unsigned ADDR_W = ROW_W + COL_W,
   localparam int unsigned IDX_W  = (NUM > 1) ? $clog2(NUM) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_shift,
   input  logic               ser_data,
   input  logic               ser_stb,
   input  logic [ADDR_W-1:0]  ser_addr,
   input  logic               cal_we,
   input  logic [ADDR_W-1:0]  cal_addr,
   input  logic [PHASE_W-1:0] cal_val,
   output logic [NUM-1:0]     mod_clk,
   output logic [ROWS-1:0]    mod_data,
   output logic [ROWS-1:0]    mod_stb
);

   if (ROWS < 1 || COLS < 1 || NUM < 2) begin : g_bad_grid
      $error("sa_module_dist: grid needs at least two elements");
   end

   // ---------------- address decode ----------------
   function automatic logic in_grid(input logic [ADDR_W-1:0] a);
      logic [ROW_W:0] r;
      logic [COL_W:0] c;
      r = {1'b0, a[ADDR_W-1 -: ROW_W]};
      c = {1'b0, a[COL_W-1:0]};
      return (r < (ROW_W+1)'(ROWS)) && (c < (COL_W+1)'(COLS));
   endfunction

   function automatic logic [IDX_W-1:0] elem_of(input logic [ADDR_W-1:0] a);
      if (!in_grid(a)) return '0;
      return IDX_W'(a[ADDR_W-1 -: ROW_W]) * IDX_W'(COLS) + IDX_W'(a[COL_W-1:0]);
   endfunction

   logic             s_hit;
   logic [IDX_W-1:0] s_idx;
   logic [IDX_W-1:0] c_idx;
   logic             c_wr;

   assign s_hit = in_grid(ser_addr);
   assign s_idx = elem_of(ser_addr);
   assign c_idx = elem_of(cal_addr);
   assign c_wr  = cal_we && in_grid(cal_addr);

   // ---------------- calibration store ----------------
   logic [PHASE_W-1:0] s_off;

   sa_dist_cal_table #(.NUM(NUM), .IDX_W(IDX_W)) u_cal (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (c_wr),
      .wr_idx (c_idx),
      .wr_val (cal_val),
      .rd_idx (s_idx),
      .rd_val (s_off)
   );

   // ---------------- capture / correct / re-send ----------------
   logic             tx_bit;
   logic             tx_busy;
   logic [ROW_W-1:0] tx_row;
   logic [COL_W-1:0] tx_col;
   logic             tx_hit;
   logic             tx_stb;

   sa_dist_serializer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .sh_en   (ser_shift),
      .sh_bit  (ser_data),
      .ld_en   (ser_stb),
      .ld_row  (ser_addr[ADDR_W-1 -: ROW_W]),
      .ld_col  (ser_addr[COL_W-1:0]),
      .ld_hit  (s_hit),
      .ld_off  (s_off),
      .tx_bit  (tx_bit),
      .tx_busy (tx_busy),
      .tx_row  (tx_row),
      .tx_col  (tx_col),
      .tx_hit  (tx_hit),
      .tx_stb  (tx_stb)
   );

   // ---------------- row fan-out ----------------
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic sel;
      assign sel         = tx_hit && (tx_row == ROW_W'(r));
      assign mod_data[r] = sel && tx_busy && tx_bit;
      assign mod_stb[r]  = tx_stb && (tx_row == ROW_W'(r));
   end

   // ---------------- per-element clock steering ----------------
   logic [NUM-1:0] gate_req;
   logic [NUM-1:0] gate_en;

   for (genvar e = 0; e < NUM; e++) begin : g_elem
      localparam int unsigned ER = e / COLS;
      localparam int unsigned EC = e % COLS;
      assign gate_req[e] = tx_busy && tx_hit &&
                           (tx_row == ROW_W'(ER)) && (tx_col == COL_W'(EC));
      sa_dist_clk_gate u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_req (gate_req[e]),
         .en_o   (gate_en[e]),
         .gclk   (mod_clk[e])
      );
   end

   // R4: never more than one module clock enabled
   assert_single_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_en));

   // R5: strobe reaches one row at most
   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mod_stb));

   // R6: only the row being written may carry data, and only while shifting
   assert_idle_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mod_data) && (!tx_busy -> (mod_data == '0)));

   // R7: an off-grid word steers nothing
   assert_off_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_stb && !s_hit) |=> ((gate_req == '0) && (mod_data == '0) && (mod_stb == '0)));

endmodule

// File: tb/sa_module_dist_tb.sv
module sa_module_dist_tb;

   localparam int ROWS = 3;
   localparam int COLS = 6;
   localparam int NUM  = ROWS * COLS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_shift = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_stb = 1'b0;
   logic [4:0]  ser_addr = '0;
   logic        cal_we = 1'b0;
   logic [4:0]  cal_addr = '0;
   logic [6:0]  cal_val = '0;
   logic [NUM-1:0]  mod_clk;
   logic [ROWS-1:0] mod_data;
   logic [ROWS-1:0] mod_stb;

   always #2 clk = ~clk;   // 250 MHz

   sa_module_dist #(.ROWS(ROWS), .COLS(COLS)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_data(ser_data),
      .ser_stb(ser_stb), .ser_addr(ser_addr), .cal_we(cal_we),
      .cal_addr(cal_addr), .cal_val(cal_val), .mod_clk(mod_clk),
      .mod_data(mod_data), .mod_stb(mod_stb)
   );

   int n_vec  = 0;
   int n_fail = 0;
   bit b2b    = 0;
   bit done   = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, got, exp);
      end
   endtask

   // ---------------- behavioural modules ----------------
   logic [7:0] ap_arr [NUM];
   for (genvar g = 0; g < NUM; g++) begin : g_mod
      logic [7:0] sh = '0;
      logic [7:0] ap = '0;
      always @(posedge mod_clk[g]) sh <= {sh[6:0], mod_data[g / COLS]};
      always @(posedge mod_stb[g / COLS]) ap <= sh;
      assign ap_arr[g] = ap;
   end

   // ---------------- reference model ----------------
   logic [6:0] cal_m [NUM];
   logic [7:0] exp_ap [NUM];
   logic [7:0] m_in = '0;
   logic [7:0] m_word = '0;
   int m_cnt = 0, prev_cnt = 0, m_row = 0, m_col = 0;
   bit m_hit = 0, stb_exp = 0;

   initial for (int i = 0; i < NUM; i++) begin cal_m[i] = '0; exp_ap[i] = '0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_in = '0; m_cnt = 0; prev_cnt = 0; m_hit = 0; stb_exp = 0;
         for (int i = 0; i < NUM; i++) cal_m[i] = '0;
      end else begin
         int rr, cc, wr, wc;
         prev_cnt = m_cnt;
         stb_exp  = (m_cnt == 1) && m_hit;
         if (ser_stb) begin
            rr = int'(ser_addr[4:3]); cc = int'(ser_addr[2:0]);
            m_row = rr; m_col = cc;
            m_hit = (rr < ROWS) && (cc < COLS);
            m_word[7]   = m_in[7];
            m_word[6:0] = m_hit ? 7'(m_in[6:0] + cal_m[rr*COLS+cc]) : m_in[6:0];
            m_cnt = 8;
         end else if (m_cnt > 0) begin
            m_cnt--;
         end
         if (ser_shift) m_in = {m_in[6:0], ser_data};
         if (cal_we) begin
            wr = int'(cal_addr[4:3]); wc = int'(cal_addr[2:0]);
            if (wr < ROWS && wc < COLS) cal_m[wr*COLS+wc] = cal_val;
         end
      end
   end

   // per-clock comparison in the high phase
   always @(posedge clk) begin
      logic [NUM-1:0]  e_clk;
      logic [ROWS-1:0] e_dat, e_stb;
      #1;
      e_clk = '0; e_dat = '0; e_stb = '0;
      if (prev_cnt > 0 && m_hit) e_clk[m_row*COLS+m_col] = 1'b1;
      if (m_cnt > 0 && m_hit)    e_dat[m_row] = m_word[m_cnt-1];
      if (stb_exp)               e_stb[m_row] = 1'b1;
      if (!rst_n) begin
         chk("R10 clk", 32'(mod_clk), 32'(e_clk));
         chk("R10 data", 32'(mod_data), 32'(e_dat));
         chk("R10 strobe", 32'(mod_stb), 32'(e_stb));
      end else begin
         chk(b2b ? "R9 clk" : "R3 clk", 32'(mod_clk & e_clk), 32'(e_clk));
         chk(m_hit ? "R4 other clk" : "R7 clk", 32'(mod_clk & ~e_clk), 32'd0);
         chk(m_hit ? (b2b ? "R9 data" : "R3 data") : "R7 data", 32'(mod_data & e_dat), 32'(e_dat));
         chk("R6 idle data", 32'(mod_data & ~e_dat), 32'd0);
         chk(m_hit ? "R5 strobe" : "R7 strobe", 32'(mod_stb), 32'(e_stb));
      end
   end

   // low phase: every module clock low
   always @(negedge clk) begin
      #1;
      chk("R11 low phase", 32'(mod_clk), 32'd0);
   end

   // ---------------- stimulus ----------------
   task automatic cal_write(input int r, input int c, input logic [6:0] v);
      cal_we = 1'b1; cal_addr = {2'(r), 3'(c)}; cal_val = v;
      @(negedge clk);
      cal_we = 1'b0;
   endtask

   task automatic send_word(input int r, input int c, input logic [7:0] w,
                            input int junk, input int gap);
      for (int j = 0; j < junk; j++) begin
         ser_shift = 1'b1; ser_data = ~j[0]; @(negedge clk);
      end
      for (int b = 7; b >= 0; b--) begin
         ser_shift = 1'b1; ser_data = w[b]; @(negedge clk);
      end
      ser_shift = 1'b0; ser_stb = 1'b1; ser_addr = {2'(r), 3'(c)};
      if (r < ROWS && c < COLS)
         exp_ap[r*COLS+c] = {w[7], 7'(w[6:0] + cal_m[r*COLS+c])};
      @(negedge clk);
      ser_stb = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      send_word(0, 0, 8'h85, 0, 10);                 // R1 plain word
      cal_write(0, 1, 7'd10);                        // R8 writes
      cal_write(1, 5, 7'd127);
      cal_write(2, 3, 7'd64);
      cal_write(0, 6, 7'd55);                        // R8 off-grid, must not hit (1,0)
      cal_write(3, 0, 7'd21);
      @(negedge clk);
      send_word(0, 1, 8'h7F, 0, 10);                 // R2 wrap
      send_word(1, 5, 8'h01, 0, 10);
      send_word(2, 3, 8'hC0, 0, 10);
      send_word(1, 0, 8'h33, 0, 10);                 // R8 offset still zero
      send_word(3, 2, 8'hFF, 0, 10);                 // R7 row off grid
      send_word(0, 7, 8'hAA, 0, 10);                 // R7 column off grid
      send_word(2, 0, 8'h5A, 3, 10);                 // R1 leading junk bits dropped

      b2b = 1;                                       // R9 back-to-back words
      send_word(2, 1, 8'hE1, 0, 0);
      send_word(2, 2, 8'h1E, 0, 0);
      send_word(0, 2, 8'h99, 0, 0);
      send_word(1, 4, 8'h66, 0, 12);
      b2b = 0;

      for (int i = 0; i < NUM; i++)
         if (i != 6) cal_write(i / COLS, i % COLS, 7'(i * 11 + 3));
      for (int i = 0; i < NUM; i++)
         send_word(i / COLS, i % COLS, 8'(i * 37 + 5), 0, (i % 3 == 0) ? 0 : 2);
      repeat (12) @(negedge clk);

      for (int i = 0; i < NUM; i++)
         chk((i == 6) ? "R8 applied" : ((cal_m[i] != 0) ? "R2 applied" : "R1 applied"),
             32'(ap_arr[i]), 32'(exp_ap[i]));

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule